// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI bus master that works through a list of up to sixteen word transfers on its own. Software loads three small on-chip tables through an indirect window: outgoing words, per-entry command bits and, after the run, the incoming words. It then sets a start pointer and an end pointer and starts the run. The block shifts each entry in turn and files the received word under the same index. At the end it drops its run bit by itself and raises a done flag, which can drive an interrupt line.

The register file is 16 bits wide. It sits on a plain strobe bus: `bus_wr` and `bus_rd` are single-cycle strobes, and read data is combinational from the current state. The serial side provides clock polarity and phase, a per-entry word width of 8 to 16 bits, and a clock divider. Chip-select generation, inter-transfer delays and slave operation belong to neighbouring logic.

Top module: `qspi_master`

## Requirements
- R1: After reset every register reads zero, `sck` and `mosi` are low and `irq` is low.
- R2: Offset 0x10 holds a 6-bit table pointer. Pointer values 0x00–0x0F address the outgoing-word table, 0x10–0x1F the incoming-word table and 0x20–0x2F the command table. Every read or accepted write at offset 0x14 accesses the addressed entry and then advances the pointer by one. The incoming table cannot be written from the bus.
- R3: Software can write and read back the mode register at 0x00, the run register at 0x04 (bits 14:0), the loop register at 0x08 and the interrupt enables at 0x0C (bits 15:8).
- R4: Writing 1 to bit 15 at 0x04 while idle starts a run. The run visits the entries from the start index (0x08 bits 3:0) upward to the end index (0x08 bits 11:8), wrapping from 15 to 0. Entries outside that span keep their incoming-table contents.
- R5: Each entry sends its outgoing word MSB first, using only its low N bits. The received bits are stored at the same index, right-justified, with the unused upper bits zero.
- R6: If command bit 14 is clear, N is 8. If it is set, N comes from mode bits 13:10: 0 means 16, 8–15 are taken as is, and 1–7 are raised to 8.
- R7: Each half period of `sck` lasts D clock cycles, where D is mode bits 7:0. If D is 0, `sck` stays frozen and the run does not advance until D becomes nonzero.
- R8: Mode bit 9 sets the idle level of `sck`. With mode bit 8 clear, data is captured on the leading edge of each bit. With it set, data is captured on the trailing edge. Each entry produces exactly N capture edges.
- R9: At the end of the last entry the hardware clears bit 15 at 0x04. The done flag (0x0C bit 0) is set in that same cycle.
- R10: `irq` is high exactly while the done flag and its enable (0x0C bit 8) are both set.
- R11: The flags at 0x0C bits 0, 2 and 3 are cleared by writing 1 to them; writing 0 leaves them unchanged. A hardware set in the same cycle takes priority over a clear.
- R12: A write to 0x14 during a run is dropped. It sets the collision flag (0x0C bit 3) and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (advances the pointer at 0x14) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| irq | output | 1 | Done interrupt |

## Verification
Register reads take effect in the same cycle: the bench drives a read on a falling edge and samples `bus_rdata` 1 ns later. Writes, pointer steps and flag changes therefore show up on the read issued at the next falling edge. A run's completion time depends on D and the widths, so the bench polls bit 15 at 0x04. In the cycle it sees that bit clear, it also expects the done flag set (R9) before it reads back the incoming table. A monitor on `sck` counts clock cycles between edges and must measure a shortest gap of exactly D (R7). It also collects `mosi` on the capture edge that the phase selects and compares the stream bit for bit with the expected MSB-first sequence.

// File: rtl/qspi_pkg.sv
// Package: register offsets, field positions, sequencer types and the
// word-width decode shared by the queued SPI master.
package qspi_pkg;

    localparam int REG_W = 16;

    // Register byte offsets on the local bus.
    localparam logic [4:0] OFS_MODE = 5'h00;
    localparam logic [4:0] OFS_RUN  = 5'h04;
    localparam logic [4:0] OFS_LOOP = 5'h08;
    localparam logic [4:0] OFS_FLAG = 5'h0C;
    localparam logic [4:0] OFS_PTR  = 5'h10;
    localparam logic [4:0] OFS_PORT = 5'h14;

    // Field positions that the sequencer and shifter decode.
    localparam int MODE_CPOL  = 9;
    localparam int MODE_CPHA  = 8;
    localparam int RUN_GO     = 15;
    localparam int FLG_DONE   = 0;
    localparam int FLG_ABORT  = 2;
    localparam int FLG_WCOL   = 3;
    localparam int CMD_FULLW  = 14;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SHIFT
    } seq_state_t;

    typedef enum logic [1:0] {
        BANK_TX   = 2'd0,
        BANK_RX   = 2'd1,
        BANK_CMD  = 2'd2,
        BANK_NONE = 2'd3
    } bank_t;

    // Bits per word: 8 unless the entry asks for the programmed width.
    function automatic logic [4:0] word_bits(input logic [3:0] wfield,
                                             input logic       full);
        if (!full)           return 5'd8;
        if (wfield == 4'd0)  return 5'd16;
        if (wfield < 4'd8)   return 5'd8;
        return {1'b0, wfield};
    endfunction

endpackage

// File: rtl/qspi_qram.sv
// Queue table: DEPTH words of WIDTH bits held in flops, one synchronous
// write port and NRD combinational read ports.
// Assumes: each writer owns the port for the whole cycle; reset clears all entries.
module qspi_qram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int NRD   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read path per requested port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/qspi_shift.sv
// Bit engine: shifts one word of nbits MSB first under the selected clock
// polarity and phase, and collects the same number of bits from miso.
// Assumes: start is only raised while idle; a div of zero stalls the word.
module qspi_shift #(
    parameter int W     = 16,
    parameter int DIV_W = 8,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     tx_word,
    input  logic [CNT_W-1:0] nbits,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     rx_word,
    output logic             sck,
    output logic             mosi
);

    logic [DIV_W-1:0] hcnt_q;
    logic [CNT_W:0]   ecnt_q;
    logic [CNT_W-1:0] nbits_q;
    logic [W-1:0]     sh_q;
    logic [W-1:0]     rx_q;
    logic             sck_q, mosi_q, busy_q, done_q;

    logic [W-1:0]     aligned;
    logic [CNT_W:0]   last_edge;
    logic             tick, lead, capture;

    // Left-justify the active bits so the first one sits at the top.
    assign aligned   = tx_word << (W - int'(nbits));
    assign last_edge = {nbits_q, 1'b0} - 1'b1;
    assign tick      = busy_q && (div != '0) && (hcnt_q >= div - 1'b1);
    assign lead      = ~ecnt_q[0];
    assign capture   = lead ^ cpha;

    // Word sequencing: load, count half periods, toggle, capture or drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q  <= '0;
            ecnt_q  <= '0;
            nbits_q <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                sck_q <= cpol;
                if (start) begin
                    busy_q  <= 1'b1;
                    hcnt_q  <= '0;
                    ecnt_q  <= '0;
                    rx_q    <= '0;
                    nbits_q <= nbits;
                    if (cpha) begin
                        sh_q <= aligned;
                    end else begin
                        sh_q   <= aligned << 1;
                        mosi_q <= aligned[W-1];
                    end
                end
            end else if (tick) begin
                hcnt_q <= '0;
                sck_q  <= ~sck_q;
                ecnt_q <= ecnt_q + 1'b1;
                if (capture) begin
                    rx_q <= {rx_q[W-2:0], miso};
                end else begin
                    mosi_q <= sh_q[W-1];
                    sh_q   <= sh_q << 1;
                end
                if (ecnt_q == last_edge) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (div != '0) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_word = rx_q;
    assign sck     = sck_q;
    assign mosi    = mosi_q;

    // R7: with a zero divisor the serial clock holds its level.
    a_r7_div0_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && div == '0) |=> $stable(sck_q));

    // R5: a word completes only out of an active shift.
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    // R8: between words the clock follows the programmed idle level.
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && $past(!busy_q) && $past(rst_n)) |-> (sck_q == $past(cpol)));

endmodule

// File: rtl/qspi_master.sv
// Queued SPI master top: register file on a strobe bus, indirect access to
// the three queue tables, and the sequencer that walks start..end through
// the bit engine.
// Assumes: a single-cycle bus strobe; reads are side-effect free except at
// the data port, where every access advances the table pointer.
module qspi_master #(
    parameter int QDEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        irq
);
    import qspi_pkg::*;

    localparam int IDX_W = $clog2(QDEPTH);
    localparam int PTR_W = IDX_W + 2;
    localparam int CNT_W = $clog2(REG_W + 1);
    localparam int DIV_W = 8;

    // Register state.
    logic [REG_W-1:0] mode_q, loop_q;
    logic [REG_W-2:0] run_lo_q;
    logic             run_q;
    logic             f_done_q, f_abort_q, f_wcol_q;
    logic [7:0]       ie_q;
    logic [PTR_W-1:0] ptr_q;

    // Sequencer state.
    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             finish;

    // Bus decode.
    logic wr_mode, wr_run, wr_loop, wr_flag, wr_ptr, port_wr, port_rd, collide;
    assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
    assign wr_run  = bus_wr && (bus_addr == OFS_RUN);
    assign wr_loop = bus_wr && (bus_addr == OFS_LOOP);
    assign wr_flag = bus_wr && (bus_addr == OFS_FLAG);
    assign wr_ptr  = bus_wr && (bus_addr == OFS_PTR);
    assign port_wr = bus_wr && (bus_addr == OFS_PORT);
    assign port_rd = bus_rd && (bus_addr == OFS_PORT);
    assign collide = port_wr && run_q;

    bank_t            bank;
    logic [IDX_W-1:0] slot;
    assign bank = bank_t'(ptr_q[PTR_W-1:IDX_W]);
    assign slot = ptr_q[IDX_W-1:0];

    // Queue tables: tx and cmd read by bus and sequencer, rx by bus only.
    logic [1:0][REG_W-1:0] tx_rd, cmd_rd;
    logic [0:0][REG_W-1:0] rx_rd;
    logic                  sh_start, sh_busy, sh_done;
    logic [REG_W-1:0]      sh_rx;
    logic [CNT_W-1:0]      nbits;

    qspi_qram #(.DEPTH(QDEPTH), .WIDTH(REG_W), .NRD(2)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .we(port_wr && !run_q && bank == BANK_TX),
        .waddr(slot), .wdata(bus_wdata),
        .raddr({idx_q, slot}), .rdata(tx_rd)
    );

    qspi_qram #(.DEPTH(QDEPTH), .WIDTH(REG_W), .NRD(2)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .we(port_wr && !run_q && bank == BANK_CMD),
        .waddr(slot), .wdata(bus_wdata),
        .raddr({idx_q, slot}), .rdata(cmd_rd)
    );

    qspi_qram #(.DEPTH(QDEPTH), .WIDTH(REG_W), .NRD(1)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .we(state_q == SEQ_SHIFT && sh_done),
        .waddr(idx_q), .wdata(sh_rx),
        .raddr(slot), .rdata(rx_rd)
    );

    // Command bits other than the width select belong to neighbouring logic.
    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_rd[1][REG_W-1:CMD_FULLW+1], cmd_rd[1][CMD_FULLW-1:0]};

    assign nbits    = word_bits(mode_q[13:10], cmd_rd[1][CMD_FULLW]);
    assign sh_start = (state_q == SEQ_LOAD);

    qspi_shift #(.W(REG_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .tx_word(tx_rd[1]), .nbits(nbits),
        .cpol(mode_q[MODE_CPOL]), .cpha(mode_q[MODE_CPHA]),
        .div(mode_q[DIV_W-1:0]), .miso(miso),
        .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
        .sck(sck), .mosi(mosi)
    );

    // Plain configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            loop_q   <= '0;
            run_lo_q <= '0;
            ie_q     <= '0;
        end else begin
            if (wr_mode) mode_q   <= bus_wdata;
            if (wr_loop) loop_q   <= bus_wdata;
            if (wr_run)  run_lo_q <= bus_wdata[REG_W-2:0];
            if (wr_flag) ie_q     <= bus_wdata[15:8];
        end
    end

    // Table pointer: loaded from the bus, stepped on each accepted port access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_ptr) begin
            ptr_q <= bus_wdata[PTR_W-1:0];
        end else if (port_rd || (port_wr && !run_q)) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Sticky flags: hardware set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_done_q  <= 1'b0;
            f_abort_q <= 1'b0;
            f_wcol_q  <= 1'b0;
        end else begin
            if (finish)                          f_done_q  <= 1'b1;
            else if (wr_flag && bus_wdata[FLG_DONE])  f_done_q  <= 1'b0;
            if (wr_flag && bus_wdata[FLG_ABORT])      f_abort_q <= 1'b0;
            if (collide)                         f_wcol_q  <= 1'b1;
            else if (wr_flag && bus_wdata[FLG_WCOL])  f_wcol_q  <= 1'b0;
        end
    end

    // Queue walk: start index to end index, one entry per bit-engine word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (wr_run && bus_wdata[RUN_GO]) begin
                    run_q   <= 1'b1;
                    idx_q   <= loop_q[IDX_W-1:0];
                    state_q <= SEQ_LOAD;
                end
                SEQ_LOAD: state_q <= SEQ_SHIFT;
                SEQ_SHIFT: if (sh_done) begin
                    if (idx_q == loop_q[8+IDX_W-1:8]) begin
                        run_q   <= 1'b0;
                        state_q <= SEQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SEQ_LOAD;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign finish = (state_q == SEQ_SHIFT) && sh_done && (idx_q == loop_q[8+IDX_W-1:8]);
    assign irq    = f_done_q && ie_q[0];

    // Read mux; the data port shows the entry the pointer selects.
    logic [REG_W-1:0] port_word;
    always_comb begin
        case (bank)
            BANK_TX:  port_word = tx_rd[0];
            BANK_RX:  port_word = rx_rd[0];
            BANK_CMD: port_word = cmd_rd[0];
            default:  port_word = '0;
        endcase
    end

    // Register read selection by offset.
    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_RUN:  bus_rdata = {run_q, run_lo_q};
            OFS_LOOP: bus_rdata = loop_q;
            OFS_FLAG: bus_rdata = {ie_q, 4'b0, f_wcol_q, f_abort_q, 1'b0, f_done_q};
            OFS_PTR:  bus_rdata = {{(REG_W-PTR_W){1'b0}}, ptr_q};
            OFS_PORT: bus_rdata = port_word;
            default:  bus_rdata = '0;
        endcase
    end

    // R9: the run bit only drops together with a raised done flag.
    a_r9_done_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> f_done_q);

    // R12: a port write during a run flags a collision.
    a_r12_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && run_q) |=> f_wcol_q);

    // R12: a rejected port write leaves the pointer where it was.
    a_r12_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && run_q) |=> (ptr_q == $past(ptr_q)));

    // R2: each accepted port access steps the pointer by one.
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd || (port_wr && !run_q)) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R4: the sequencer is only away from idle while the run bit is set.
    a_r4_busy_means_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE || sh_busy) |-> run_q);

endmodule

// File: tb/sim_qspi_master.sv
`timescale 1ns/1ps
module sim_qspi_master;

    localparam logic [4:0] A_MODE = 5'h00, A_RUN = 5'h04, A_LOOP = 5'h08,
                           A_FLAG = 5'h0C, A_PTR = 5'h10, A_PORT = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, irq, miso;

    assign miso = mosi;   // loopback slave

    qspi_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miso(miso), .sck(sck), .mosi(mosi), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [15:0] tx_w [16];
    logic        cmd_f [16];
    logic [15:0] exp_rx [16];
    logic        exp_str [512];
    int          exp_cnt;
    logic [7:0]  ie_cur = 8'h00;

    // SPI monitor state.
    logic cur_cpol = 1'b0, cur_cpha = 1'b0, mon_clr = 1'b0, sck_prev = 1'b0;
    logic mon_bits [512];
    int   mon_cnt = 0, min_gap = 1000000, cyc = 0, last_edge = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            mon_cnt = 0; min_gap = 1000000; last_edge = cyc;
        end else if (sck != sck_prev) begin
            if (((sck != cur_cpol) ^ cur_cpha) && mon_cnt < 512) begin
                mon_bits[mon_cnt] = mosi;
                mon_cnt = mon_cnt + 1;
            end
            if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
            last_edge = cyc;
        end
        sck_prev = sck;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic int ebits(input logic [3:0] wf, input logic full);
        if (!full) return 8;
        if (wf == 4'd0) return 16;
        if (wf < 4'd8) return 8;
        return int'(wf);
    endfunction

    task automatic load_tables(input logic pol, input logic pha, input logic [7:0] dv,
                               input logic [3:0] wf, input logic [3:0] s, input logic [3:0] e);
        int idx, nb;
        bus_write(A_MODE, {2'b10, wf, pol, pha, dv});
        bus_write(A_PTR, 16'h0020);
        for (int i = 0; i < 16; i++) bus_write(A_PORT, cmd_f[i] ? 16'h4000 : 16'h0000);
        bus_write(A_PTR, 16'h0000);
        for (int i = 0; i < 16; i++) bus_write(A_PORT, tx_w[i]);
        bus_write(A_LOOP, {4'b0, e, 4'b0, s});
        cur_cpol = pol; cur_cpha = pha;
        #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
        exp_cnt = 0; idx = int'(s);
        for (int n = 0; n < 16; n++) begin
            nb = ebits(wf, cmd_f[idx]);
            exp_rx[idx] = tx_w[idx] & 16'((32'd1 << nb) - 1);
            for (int b = nb - 1; b >= 0; b--) begin
                exp_str[exp_cnt] = tx_w[idx][b];
                exp_cnt++;
            end
            if (idx == int'(e)) break;
            idx = (idx + 1) % 16;
        end
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int guard = 0;
        do begin bus_read(A_RUN, v); guard++; end while (v[15] && guard < 20000);
        check(!v[15], "R9 run bit cleared", v, 0);
        bus_read(A_FLAG, v);
        check(v[0], "R9 done flag at stop", v[0], 1);
        check(irq == ie_cur[0], "R10 irq follows done and enable", irq, ie_cur[0]);
    endtask

    task automatic verify_run(input logic pol, input logic [7:0] dv);
        logic [15:0] v;
        int mism = 0;
        bus_write(A_PTR, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            bus_read(A_PORT, v);
            check(v == exp_rx[i], "R5 rx entry", v, exp_rx[i]);
        end
        check(mon_cnt == exp_cnt, "R8 capture edge count", mon_cnt, exp_cnt);
        for (int i = 0; i < exp_cnt && i < mon_cnt; i++)
            if (mon_bits[i] != exp_str[i]) mism++;
        check(mism == 0, "R5 mosi stream MSB first", mism, 0);
        check(min_gap == int'(dv), "R7 half period", min_gap, dv);
        check(sck == pol, "R8 idle level", sck, pol);
        bus_write(A_FLAG, {ie_cur, 8'h01});
        check(irq == 1'b0, "R11 done cleared", irq, 0);
    endtask

    task automatic run_queue(input logic pol, input logic pha, input logic [7:0] dv,
                             input logic [3:0] wf, input logic [3:0] s, input logic [3:0] e);
        load_tables(pol, pha, dv, wf, s, e);
        bus_write(A_RUN, 16'h8000);
        wait_idle();
        verify_run(pol, dv);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) exp_rx[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        bus_read(A_MODE, v); check(v == 0, "R1 mode reset", v, 0);
        bus_read(A_RUN, v);  check(v == 0, "R1 run reset", v, 0);
        bus_read(A_LOOP, v); check(v == 0, "R1 loop reset", v, 0);
        bus_read(A_FLAG, v); check(v == 0, "R1 flag reset", v, 0);
        bus_read(A_PTR, v);  check(v == 0, "R1 pointer reset", v, 0);
        check(sck == 0 && mosi == 0 && irq == 0, "R1 pins reset", {sck, mosi, irq}, 0);

        // R3: register readback
        bus_write(A_MODE, 16'h3A05); bus_read(A_MODE, v); check(v == 16'h3A05, "R3 mode", v, 16'h3A05);
        bus_write(A_LOOP, 16'h5C3A); bus_read(A_LOOP, v); check(v == 16'h5C3A, "R3 loop", v, 16'h5C3A);
        bus_write(A_RUN, 16'h1234);  bus_read(A_RUN, v);  check(v == 16'h1234, "R3 run low bits", v, 16'h1234);
        bus_write(A_FLAG, 16'hA500); bus_read(A_FLAG, v); check(v == 16'hA500, "R3 enables", v, 16'hA500);
        bus_write(A_FLAG, 16'h0000);

        // R2: pointer stepping and bank selection
        bus_write(A_PTR, 16'h0020);
        bus_write(A_PORT, 16'h4000); bus_write(A_PORT, 16'h0000); bus_write(A_PORT, 16'h4000);
        bus_read(A_PTR, v); check(v == 16'h0023, "R2 pointer after writes", v, 16'h23);
        bus_write(A_PTR, 16'h0021); bus_read(A_PORT, v); check(v == 16'h0000, "R2 cmd readback", v, 0);
        bus_read(A_PORT, v); check(v == 16'h4000, "R2 cmd readback", v, 16'h4000);
        bus_write(A_PTR, 16'h0012); bus_write(A_PORT, 16'hFFFF);
        bus_write(A_PTR, 16'h0012); bus_read(A_PORT, v); check(v == 16'h0000, "R2 rx not writable", v, 0);
        bus_read(A_PTR, v); check(v == 16'h0013, "R2 pointer after read", v, 16'h13);

        // R6: width forced to 8 with command bit 14 clear; full 16-entry run
        for (int i = 0; i < 16; i++) begin tx_w[i] = 16'(32'h1357 * (i + 3)); cmd_f[i] = 1'b0; end
        run_queue(1'b0, 1'b0, 8'd2, 4'd12, 4'd0, 4'd15);

        // R4/R6: 16-bit words, wrap from 14 round to 1, mode 3
        for (int i = 0; i < 16; i++) begin tx_w[i] = 16'hC0DE ^ 16'(i * 16'h0911); cmd_f[i] = 1'b1; end
        run_queue(1'b1, 1'b1, 8'd3, 4'd0, 4'd14, 4'd1);

        // R10: single entry with interrupt enabled, widths 1..7 raised to 8
        ie_cur = 8'h01;
        bus_write(A_FLAG, {ie_cur, 8'h00});
        tx_w[5] = 16'hF0A5;
        run_queue(1'b0, 1'b1, 8'd2, 4'd3, 4'd5, 4'd5);
        ie_cur = 8'h00;
        bus_write(A_FLAG, 16'h0000);

        // Random queues
        for (int r = 0; r < 5; r++) begin
            logic [3:0] wf, s, e;
            for (int i = 0; i < 16; i++) begin
                tx_w[i] = 16'($urandom);
                cmd_f[i] = 1'($urandom);
            end
            wf = 4'($urandom_range(0, 15));
            s  = 4'($urandom);
            e  = 4'(s + 4'($urandom_range(0, 6)));
            run_queue(1'($urandom), 1'($urandom), 8'($urandom_range(2, 4)), wf, s, e);
        end

        // R7: divisor zero stalls the run until a nonzero divisor arrives
        for (int i = 0; i < 16; i++) cmd_f[i] = 1'b1;
        tx_w[0] = 16'h9C3B;
        load_tables(1'b0, 1'b0, 8'd0, 4'd10, 4'd0, 4'd0);
        bus_write(A_RUN, 16'h8000);
        repeat (40) @(negedge clk);
        check(mon_cnt == 0 && sck == 1'b0, "R7 frozen clock", mon_cnt, 0);
        bus_read(A_RUN, v); check(v[15], "R7 run still pending", v[15], 1);
        bus_write(A_MODE, {2'b10, 4'd10, 1'b0, 1'b0, 8'd2});
        wait_idle();
        verify_run(1'b0, 8'd2);

        // R12/R11: collision during a long run, then write-one clear
        for (int i = 0; i < 16; i++) begin tx_w[i] = 16'hA55A + 16'(i); cmd_f[i] = 1'b1; end
        load_tables(1'b1, 1'b0, 8'd4, 4'd0, 4'd0, 4'd15);
        bus_write(A_RUN, 16'h8000);
        bus_write(A_PTR, 16'h0003);
        bus_write(A_PORT, 16'hBEEF);
        bus_read(A_PTR, v);  check(v == 16'h0003, "R12 pointer held", v, 3);
        bus_read(A_FLAG, v); check(v[3], "R12 collision flag", v[3], 1);
        wait_idle();
        bus_write(A_FLAG, 16'h0000);
        bus_read(A_FLAG, v); check(v[0] && v[3], "R11 write zero keeps flags", v, 16'h9);
        verify_run(1'b1, 8'd4);
        bus_write(A_PTR, 16'h0003); bus_read(A_PORT, v);
        check(v == tx_w[3], "R12 dropped write", v, tx_w[3]);
        bus_write(A_FLAG, 16'h0008);
        bus_read(A_FLAG, v); check(v[3] == 1'b0, "R11 collision cleared", v[3], 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule